// File: doc/BRIEF.md
# Mixed-Width Configurable Block RAM

A 512-bit embedded memory with two ports, A and B, that view one shared bit array through word widths of their own. Each port is set by parameter to 1, 2, 4, 8 or 16 bits, so the array appears as 512x1, 256x2, 128x4, 64x8 or 32x16 from that side. Port B is never narrower than port A. A mode parameter selects one of three arrangements. In single-port mode, port A is the only live port. In simple dual-port mode, port A only writes and port B only reads. In true dual-port mode, both ports read and write.

Every port has its own clock, address, write enable, write data and read data. Writes are always synchronous. Reads are registered by default. In the single-port and simple dual-port modes a parameter can make reads combinational instead. The power-up contents of the array come from a 512-bit parameter and are loaded whenever the active-low reset is asserted.

An unsupported parameter set stops elaboration with an error. These are: a width outside the five legal values, port B narrower than port A, or combinational reads together with true dual-port mode. The priority between the two ports on a write collision is defined for ports driven from a common clock.

Top module: `mwram`

## Requirements
- R1: While rst_n is low, registered read outputs are 0; after reset, array bit i equals INIT_BITS[i] for every i.
- R2: A registered read presents the word at the address sampled at a rising clock edge just after that edge, and holds the previous word until then.
- R3: Data bit j of the word at address k on a port of width W occupies array bit k*W+j; so B word k spans A words k*R to k*R+R-1 (R = B_WIDTH/A_WIDTH), with the lowest A address in the least significant bits.
- R4: In true dual-port mode (MODE=2), a word written through port B is read back through port A according to the R3 mapping.
- R5: A registered read of the address a port writes at the same edge returns the contents from before that write.
- R6: When ports A and B write overlapping bits at the same edge, those bits take port A's data, and the remaining bits of B's word take port B's data.
- R7: In simple dual-port mode (MODE=1), rdata_a stays 0 and port B's write enable and write data change no array bit.
- R8: With ASYNC_READ=1 in MODE 0 or 1, the read output follows the address and the array contents within the same cycle, with no clock edge in between.
- R9: In single-port mode (MODE=0), port B's inputs change no array bit and rdata_b stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset; loads INIT_BITS and clears registered read data |
| clk_a | input | 1 | Port A clock |
| we_a | input | 1 | Port A write enable |
| addr_a | input | log2(512/A_WIDTH) | Port A word address |
| wdata_a | input | A_WIDTH | Port A write data |
| rdata_a | output | A_WIDTH | Port A read data |
| clk_b | input | 1 | Port B clock |
| we_b | input | 1 | Port B write enable (used in MODE=2 only) |
| addr_b | input | log2(512/B_WIDTH) | Port B word address |
| wdata_b | input | B_WIDTH | Port B write data |
| rdata_b | output | B_WIDTH | Port B read data |

## Verification
The bench goes after the cross-width bit mapping. A design that reversed the narrow-word order inside a wide word would return nibbles in swapped positions. It also drives same-edge collisions, partial and complete, where a design giving priority to port B, or dropping B's non-overlapping bits, would corrupt the stored word. Reads that hit the address being written that same cycle catch a design that forwards new data instead of returning the old word. Ignored-port writes in the single-port and simple dual-port modes, and the same-cycle response of combinational reads, catch a design that leaks writes from a disabled port or adds a register to an asynchronous path.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

    localparam int unsigned ARRAY_BITS = 512;

    typedef enum logic [1:0] {
        MODE_1RW  = 2'd0,
        MODE_1R1W = 2'd1,
        MODE_2RW  = 2'd2
    } port_mode_e;

    function automatic bit width_ok(input int unsigned w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
    endfunction

endpackage

// File: rtl/mwram_span.sv
// Expands one port's word access into array-wide bit mask and data vectors.
module mwram_span #(
    parameter int unsigned BITS = 512,
    parameter int unsigned W    = 4,
    localparam int unsigned AW  = $clog2(BITS / W),
    localparam int unsigned IW  = $clog2(BITS),
    localparam int unsigned LW  = $clog2(W)
) (
    input  logic            en,
    input  logic [AW-1:0]   addr,
    input  logic [W-1:0]    wdata,
    output logic [BITS-1:0] mask,
    output logic [BITS-1:0] spread
);

    logic [IW-1:0] base;

    assign base = IW'(addr) << LW;

    always_comb begin
        mask   = '0;
        spread = '0;
        for (int j = 0; j < W; j++) begin
            mask[base + IW'(j)]   = en;
            spread[base + IW'(j)] = wdata[j];
        end
    end

endmodule

// File: rtl/mwram_bank.sv
// One half of the shared array; a stored bit is the XOR of both halves.
module mwram_bank #(
    parameter int unsigned BITS = 512,
    parameter logic [BITS-1:0] RESET_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] mask,
    input  logic [BITS-1:0] spread,
    input  logic [BITS-1:0] other,
    output logic [BITS-1:0] half
);

    logic [BITS-1:0] next_half;

    assign next_half = (half & ~mask) | ((spread ^ other) & mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half <= RESET_VAL;
        end else begin
            half <= next_half;
        end
    end

endmodule

// File: rtl/mwram_rdport.sv
// Word extraction for one port, registered or combinational.
module mwram_rdport #(
    parameter int unsigned BITS  = 512,
    parameter int unsigned W     = 4,
    parameter bit          ASYNC = 1'b0,
    localparam int unsigned AW   = $clog2(BITS / W),
    localparam int unsigned IW   = $clog2(BITS),
    localparam int unsigned LW   = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [BITS-1:0] cells,
    output logic [W-1:0]    rdata
);

    logic [IW-1:0] base;
    logic [W-1:0]  word;

    assign base = IW'(addr) << LW;
    assign word = cells[base +: W];

    if (ASYNC) begin : g_async
        assign rdata = word;
    end else begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdata <= '0;
            end else begin
                rdata <= word;
            end
        end
    end

endmodule

// File: rtl/mwram.sv
module mwram
    import mwram_pkg::*;
#(
    parameter port_mode_e  MODE       = MODE_2RW,
    parameter int unsigned A_WIDTH    = 4,
    parameter int unsigned B_WIDTH    = 16,
    parameter bit          ASYNC_READ = 1'b0,
    parameter logic [ARRAY_BITS-1:0] INIT_BITS = '0,
    localparam int unsigned A_AW = $clog2(ARRAY_BITS / A_WIDTH),
    localparam int unsigned B_AW = $clog2(ARRAY_BITS / B_WIDTH)
) (
    input  logic               rst_n,
    input  logic               clk_a,
    input  logic               we_a,
    input  logic [A_AW-1:0]    addr_a,
    input  logic [A_WIDTH-1:0] wdata_a,
    output logic [A_WIDTH-1:0] rdata_a,
    input  logic               clk_b,
    input  logic               we_b,
    input  logic [B_AW-1:0]    addr_b,
    input  logic [B_WIDTH-1:0] wdata_b,
    output logic [B_WIDTH-1:0] rdata_b
);

    localparam bit LEGAL = width_ok(A_WIDTH) && width_ok(B_WIDTH) &&
                           (B_WIDTH >= A_WIDTH) &&
                           !(ASYNC_READ && (MODE == MODE_2RW));

    if (!LEGAL) begin : g_reject
        $error("mwram: unsupported width, width order or read-mode combination");
    end

    logic [ARRAY_BITS-1:0] mask_a;
    logic [ARRAY_BITS-1:0] spread_a;
    logic [ARRAY_BITS-1:0] half_a;
    logic [ARRAY_BITS-1:0] half_b;
    logic [ARRAY_BITS-1:0] cells;

    // Port A writes in every mode.
    mwram_span #(.BITS(ARRAY_BITS), .W(A_WIDTH)) u_span_a (
        .en     (we_a),
        .addr   (addr_a),
        .wdata  (wdata_a),
        .mask   (mask_a),
        .spread (spread_a)
    );

    mwram_bank #(.BITS(ARRAY_BITS), .RESET_VAL(INIT_BITS)) u_bank_a (
        .clk    (clk_a),
        .rst_n  (rst_n),
        .mask   (mask_a),
        .spread (spread_a),
        .other  (half_b),
        .half   (half_a)
    );

    // The second half-array exists only where port B can write.
    if (MODE == MODE_2RW) begin : g_b_writer
        logic [ARRAY_BITS-1:0] mask_b;
        logic [ARRAY_BITS-1:0] spread_b;
        logic [ARRAY_BITS-1:0] mask_b_kept;

        mwram_span #(.BITS(ARRAY_BITS), .W(B_WIDTH)) u_span_b (
            .en     (we_b),
            .addr   (addr_b),
            .wdata  (wdata_b),
            .mask   (mask_b),
            .spread (spread_b)
        );

        // Port A owns every bit it writes at the same edge.
        assign mask_b_kept = mask_b & ~mask_a;

        mwram_bank #(.BITS(ARRAY_BITS), .RESET_VAL('0)) u_bank_b (
            .clk    (clk_b),
            .rst_n  (rst_n),
            .mask   (mask_b_kept),
            .spread (spread_b),
            .other  (half_a),
            .half   (half_b)
        );
    end else begin : g_b_idle
        assign half_b = '0;
    end

    assign cells = half_a ^ half_b;

    // Port A read side: absent in simple dual-port mode.
    if (MODE != MODE_1R1W) begin : g_a_reader
        mwram_rdport #(.BITS(ARRAY_BITS), .W(A_WIDTH), .ASYNC(ASYNC_READ)) u_rd_a (
            .clk   (clk_a),
            .rst_n (rst_n),
            .addr  (addr_a),
            .cells (cells),
            .rdata (rdata_a)
        );
    end else begin : g_a_mute
        assign rdata_a = '0;
    end

    // Port B read side: absent in single-port mode.
    if (MODE != MODE_1RW) begin : g_b_reader
        mwram_rdport #(.BITS(ARRAY_BITS), .W(B_WIDTH), .ASYNC(ASYNC_READ)) u_rd_b (
            .clk   (clk_b),
            .rst_n (rst_n),
            .addr  (addr_b),
            .cells (cells),
            .rdata (rdata_b)
        );
    end else begin : g_b_mute
        assign rdata_b = '0;
    end

endmodule

// File: rtl/mwram_chk.sv
module mwram_chk
    import mwram_pkg::*;
#(
    parameter port_mode_e  MODE       = MODE_2RW,
    parameter int unsigned A_WIDTH    = 4,
    parameter int unsigned B_WIDTH    = 16,
    parameter bit          ASYNC_READ = 1'b0,
    localparam int unsigned BITS = ARRAY_BITS,
    localparam int unsigned A_AW = $clog2(BITS / A_WIDTH),
    localparam int unsigned B_AW = $clog2(BITS / B_WIDTH),
    localparam int unsigned IW   = $clog2(BITS),
    localparam int unsigned ALW  = $clog2(A_WIDTH),
    localparam int unsigned BLW  = $clog2(B_WIDTH),
    localparam int unsigned RL   = $clog2(B_WIDTH / A_WIDTH)
) (
    input logic               rst_n,
    input logic               clk_a,
    input logic               we_a,
    input logic [A_AW-1:0]    addr_a,
    input logic [A_WIDTH-1:0] wdata_a,
    input logic [A_WIDTH-1:0] rdata_a,
    input logic               clk_b,
    input logic               we_b,
    input logic [B_AW-1:0]    addr_b,
    input logic [B_WIDTH-1:0] wdata_b,
    input logic [BITS-1:0]    cells
);

    logic               a_we_q;
    logic [A_AW-1:0]    a_addr_q;
    logic [A_WIDTH-1:0] a_data_q;
    logic [A_WIDTH-1:0] a_old_q;
    logic               b_we_q;
    logic [B_AW-1:0]    b_addr_q;
    logic [B_WIDTH-1:0] b_data_q;
    logic               ovl_q;

    logic [IW-1:0]      a_base_q;
    logic [IW-1:0]      b_base_q;
    logic [A_WIDTH-1:0] a_slice;
    logic [A_WIDTH-1:0] a_cur;
    logic [B_WIDTH-1:0] b_slice;
    logic [B_WIDTH-1:0] a_lane;

    assign a_base_q = IW'(a_addr_q) << ALW;
    assign b_base_q = IW'(b_addr_q) << BLW;
    assign a_slice  = cells[a_base_q +: A_WIDTH];
    assign a_cur    = cells[(IW'(addr_a) << ALW) +: A_WIDTH];
    assign b_slice  = cells[b_base_q +: B_WIDTH];
    assign a_lane   = B_WIDTH'({A_WIDTH{1'b1}}) << (32'(a_base_q) % B_WIDTH);

    always_ff @(posedge clk_a or negedge rst_n) begin
        if (!rst_n) begin
            a_we_q   <= 1'b0;
            a_addr_q <= '0;
            a_data_q <= '0;
            a_old_q  <= '0;
        end else begin
            a_we_q   <= we_a;
            a_addr_q <= addr_a;
            a_data_q <= wdata_a;
            a_old_q  <= a_cur;
        end
    end

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n) begin
            b_we_q   <= 1'b0;
            b_addr_q <= '0;
            b_data_q <= '0;
            ovl_q    <= 1'b0;
        end else begin
            b_we_q   <= we_b && (MODE == MODE_2RW);
            b_addr_q <= addr_b;
            b_data_q <= wdata_b;
            ovl_q    <= we_a && (B_AW'(addr_a >> RL) == addr_b);
        end
    end

    // R3: a port A write lands at the bits its address maps to.
    p_a_write_lands_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
        a_we_q |-> a_slice == a_data_q);

    if (MODE == MODE_2RW) begin : g_b_props
        // R4: an uncontested port B write lands in its word.
        p_b_write_lands_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
            (b_we_q && !ovl_q) |-> b_slice == b_data_q);

        // R6: on overlap, port A's lane holds A's data.
        p_collision_a_wins_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
            (b_we_q && ovl_q) |-> a_slice == a_data_q);

        // R6: on overlap, the rest of B's word holds B's data.
        p_collision_b_rest_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
            (b_we_q && ovl_q) |-> ((b_slice ^ b_data_q) & ~a_lane) == '0);
    end

    if ((MODE != MODE_1R1W) && !ASYNC_READ) begin : g_rbw_props
        // R5: a write-and-read cycle returns the pre-write word.
        p_read_old_data_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
            a_we_q |-> rdata_a == a_old_q);
    end

endmodule

bind mwram mwram_chk #(
    .MODE       (MODE),
    .A_WIDTH    (A_WIDTH),
    .B_WIDTH    (B_WIDTH),
    .ASYNC_READ (ASYNC_READ)
) u_chk (
    .rst_n   (rst_n),
    .clk_a   (clk_a),
    .we_a    (we_a),
    .addr_a  (addr_a),
    .wdata_a (wdata_a),
    .rdata_a (rdata_a),
    .clk_b   (clk_b),
    .we_b    (we_b),
    .addr_b  (addr_b),
    .wdata_b (wdata_b),
    .cells   (cells)
);

// File: tb/mwram_test.sv
`timescale 1ns/1ps
module mwram_test;
    import mwram_pkg::*;

    localparam logic [511:0] INIT0 = {16{32'h9E37_79B9}};
    localparam logic [511:0] INIT1 = {8{64'h0123_4567_89AB_CDEF}};
    localparam logic [511:0] INIT2 = {16{32'h5A5A_C3C3}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // uut: true dual-port, 4-bit A, 16-bit B, registered reads
    logic        we_a0 = 0, we_b0 = 0;
    logic [6:0]  addr_a0 = 0;
    logic [4:0]  addr_b0 = 0;
    logic [3:0]  wdata_a0 = 0, rdata_a0;
    logic [15:0] wdata_b0 = 0, rdata_b0;

    // uut_sdp: simple dual-port, 2-bit A, 8-bit B, combinational read
    logic        we_a1 = 0, we_b1 = 0;
    logic [7:0]  addr_a1 = 0;
    logic [5:0]  addr_b1 = 0;
    logic [1:0]  wdata_a1 = 0, rdata_a1;
    logic [7:0]  wdata_b1 = 0, rdata_b1;

    // uut_sp: single-port, 8-bit A and B, registered reads
    logic        we_a2 = 0, we_b2 = 0;
    logic [5:0]  addr_a2 = 0, addr_b2 = 0;
    logic [7:0]  wdata_a2 = 0, rdata_a2, wdata_b2 = 0, rdata_b2;

    mwram #(.MODE(MODE_2RW), .A_WIDTH(4), .B_WIDTH(16), .ASYNC_READ(1'b0), .INIT_BITS(INIT0)) uut (
        .rst_n(rst_n), .clk_a(clk), .we_a(we_a0), .addr_a(addr_a0), .wdata_a(wdata_a0), .rdata_a(rdata_a0),
        .clk_b(clk), .we_b(we_b0), .addr_b(addr_b0), .wdata_b(wdata_b0), .rdata_b(rdata_b0));

    mwram #(.MODE(MODE_1R1W), .A_WIDTH(2), .B_WIDTH(8), .ASYNC_READ(1'b1), .INIT_BITS(INIT1)) uut_sdp (
        .rst_n(rst_n), .clk_a(clk), .we_a(we_a1), .addr_a(addr_a1), .wdata_a(wdata_a1), .rdata_a(rdata_a1),
        .clk_b(clk), .we_b(we_b1), .addr_b(addr_b1), .wdata_b(wdata_b1), .rdata_b(rdata_b1));

    mwram #(.MODE(MODE_1RW), .A_WIDTH(8), .B_WIDTH(8), .ASYNC_READ(1'b0), .INIT_BITS(INIT2)) uut_sp (
        .rst_n(rst_n), .clk_a(clk), .we_a(we_a2), .addr_a(addr_a2), .wdata_a(wdata_a2), .rdata_a(rdata_a2),
        .clk_b(clk), .we_b(we_b2), .addr_b(addr_b2), .wdata_b(wdata_b2), .rdata_b(rdata_b2));

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [511:0] m0 = INIT0;
    logic [511:0] m1 = INIT1;
    logic [511:0] m2 = INIT2;

    typedef struct {
        int          src;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t q[$];

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input int src, input logic [15:0] exp, input string req);
        item_t it;
        it.src = src;
        it.exp = exp;
        it.req = req;
        q.push_back(it);
    endtask

    function automatic logic [15:0] act_of(input int src);
        case (src)
            0: return {12'b0, rdata_a0};
            1: return rdata_b0;
            2: return {14'b0, rdata_a1};
            3: return {8'b0, rdata_b1};
            4: return {8'b0, rdata_a2};
            default: return {8'b0, rdata_b2};
        endcase
    endfunction

    // Monitor: results land just after a rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(it.req, act_of(it.src), it.exp);
            end
        end
    end

    // One cycle on uut: drive both ports, queue the pre-write words, update the model.
    task automatic cyc0(input logic wa_en, input int aa, input logic [3:0] wa,
                        input logic wb_en, input int ab, input logic [15:0] wb,
                        input string tag);
        we_a0 = wa_en; addr_a0 = aa[6:0]; wdata_a0 = wa;
        we_b0 = wb_en; addr_b0 = ab[4:0]; wdata_b0 = wb;
        push(0, {12'b0, m0[aa*4 +: 4]}, tag);
        push(1, m0[ab*16 +: 16], tag);
        if (wb_en) m0[ab*16 +: 16] = wb;
        if (wa_en) m0[aa*4 +: 4] = wa;
        @(negedge clk);
        we_a0 = 0;
        we_b0 = 0;
    endtask

    initial begin
        logic [31:0] lf;
        // R1: registered outputs are 0 during reset
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            push(0, 16'h0, "R1"); push(1, 16'h0, "R1");
            push(4, 16'h0, "R1"); push(5, 16'h0, "R1");
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: initial contents after reset
        addr_a2 = 6'd10;
        push(4, {8'b0, INIT2[80 +: 8]}, "R1");
        addr_b1 = 6'd7;
        #1 check("R1", {8'b0, rdata_b1}, {8'b0, INIT1[56 +: 8]});
        cyc0(0, 5, 4'h0, 0, 3, 16'h0, "R1");

        // R3: four narrow writes fill B word 3, lowest address in LSBs
        cyc0(1, 12, 4'h1, 0, 0, 16'h0, "R3");
        cyc0(1, 13, 4'h2, 0, 0, 16'h0, "R3");
        cyc0(1, 14, 4'h3, 0, 0, 16'h0, "R3");
        cyc0(1, 15, 4'h4, 0, 0, 16'h0, "R3");
        cyc0(0, 12, 4'h0, 0, 3, 16'h0, "R3");
        check("R3", m0[48 +: 16], 16'h4321);

        // R2: output holds until the next edge, then shows the new word
        addr_a0 = 7'd14;
        #1 check("R2", {12'b0, rdata_a0}, 16'h0001);
        cyc0(0, 14, 4'h0, 0, 3, 16'h0, "R2");

        // R4: B write read back through A lanes
        cyc0(0, 0, 4'h0, 1, 10, 16'hBEEF, "R4");
        cyc0(0, 40, 4'h0, 0, 10, 16'h0, "R4");
        cyc0(0, 41, 4'h0, 0, 10, 16'h0, "R4");
        cyc0(0, 43, 4'h0, 0, 10, 16'h0, "R4");
        check("R4", {12'b0, m0[160 +: 4]}, 16'h000F);

        // R5: write and read the same address in one cycle
        cyc0(1, 40, 4'h7, 1, 3, 16'h1111, "R5");
        cyc0(0, 40, 4'h0, 0, 3, 16'h0, "R5");

        // R6: collision, A lane wins, other B lanes keep B data
        cyc0(1, 13, 4'h9, 1, 3, 16'hAAAA, "R6");
        cyc0(0, 13, 4'h0, 0, 3, 16'h0, "R6");
        check("R6", m0[48 +: 16], 16'hAA9A);
        cyc0(1, 127, 4'h5, 1, 31, 16'h1234, "R6");
        cyc0(0, 127, 4'h0, 0, 31, 16'h0, "R6");

        // R3 and R6 sweep with pseudo-random traffic
        lf = 32'h1234_5678;
        for (int i = 0; i < 60; i++) begin
            int aa;
            int ab;
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            aa = int'(lf[8:2]);
            ab = lf[13] ? (aa >> 2) : int'(lf[18:14]);
            cyc0(lf[0], aa, lf[12:9], lf[1], ab, lf[31:16], "R3/R6 sweep");
        end

        // R8: combinational read follows contents and address without waiting
        addr_b1 = 6'd0;
        we_a1 = 1; addr_a1 = 8'd0; wdata_a1 = 2'b00;
        #1 check("R8", {8'b0, rdata_b1}, {8'b0, m1[0 +: 8]});
        m1[0 +: 2] = 2'b00;
        @(negedge clk);
        we_a1 = 0;
        #1 check("R8", {8'b0, rdata_b1}, {8'b0, m1[0 +: 8]});
        addr_b1 = 6'd5;
        #1 check("R8", {8'b0, rdata_b1}, {8'b0, INIT1[40 +: 8]});

        // R7: A is write-only, B writes are ignored
        @(negedge clk);
        we_a1 = 1; addr_a1 = 8'd9; wdata_a1 = 2'b01;
        push(2, 16'h0, "R7");
        m1[18 +: 2] = 2'b01;
        @(negedge clk);
        we_a1 = 0;
        addr_b1 = 6'd2;
        #1 check("R7", {8'b0, rdata_b1}, {8'b0, m1[16 +: 8]});
        we_b1 = 1; wdata_b1 = ~m1[16 +: 8];
        @(negedge clk);
        we_b1 = 0;
        #1 check("R7", {8'b0, rdata_b1}, {8'b0, m1[16 +: 8]});
        push(2, 16'h0, "R7");

        // R9: single-port instance, B inputs are inert
        @(negedge clk);
        we_a2 = 1; addr_a2 = 6'd20; wdata_a2 = 8'h3C;
        we_b2 = 1; addr_b2 = 6'd21; wdata_b2 = 8'hFF;
        push(4, {8'b0, m2[160 +: 8]}, "R9");
        push(5, 16'h0, "R9");
        m2[160 +: 8] = 8'h3C;
        @(negedge clk);
        we_a2 = 0; we_b2 = 0; addr_a2 = 6'd21;
        push(4, {8'b0, m2[168 +: 8]}, "R9");
        push(5, 16'h0, "R9");
        @(negedge clk);
        addr_a2 = 6'd20;
        push(4, 16'h003C, "R9");
        @(negedge clk);

        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule